// File: doc/BRIEF.md
# Multicast Hash Table Filter

This block decides whether the destination address of an incoming frame falls in a set of multicast groups chosen by software. Address bytes arrive one per accepted cycle on a byte stream with a valid qualifier and a start-of-frame marker. The block folds the first six accepted bytes of each frame into a 32-bit CRC, cuts a 6-bit index out of that CRC, and uses it to pick one bit of a 64-bit table that software loads through eight byte-wide registers.

One cycle after the sixth address byte is taken, a valid strobe rises together with the match flag and the index used. These results then hold until the next start-of-frame. Any later bytes of the frame, such as the payload, have no effect. The surrounding receive logic combines this flag with its other acceptance tests.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, `match_valid`, `match` and `hash_idx` are 0 and every table bit is 0, so a frame sent with no table writes gives `match` = 0.
- R2: The CRC starts at 0xFFFFFFFF on the start-of-frame byte. Each byte is taken least significant bit first, and each bit shifts the register left, XORing in polynomial 0x04C11DB7 when the outgoing bit 31 differs from the data bit. No final inversion is applied, and `hash_idx` equals CRC bits 28:23 after the sixth byte.
- R3: Destination 01-00-00-00-01-2C yields `hash_idx` = 0x34.
- R4: Index bits 5:3 pick table register `tbl_addr` 0..7 and bits 2:0 pick the bit inside it, so `match` equals bit (idx mod 8) of register (idx / 8).
- R5: `match_valid` rises in the cycle right after the sixth accepted address byte, with `match` and `hash_idx` valid in that same cycle.
- R6: Once `match_valid` is set, bytes accepted after the sixth one leave `match_valid`, `match` and `hash_idx` unchanged.
- R7: An accepted byte with `in_sof` = 1 clears `match_valid` and `match` in the next cycle. The byte counts as address byte 1 of a fresh CRC, even when it arrives partway through an address.
- R8: Cycles with `in_valid` = 0 neither advance the CRC nor count as bytes, so gaps between address bytes do not change the result.
- R9: A table write made in the same cycle as the sixth address byte is not seen by that lookup. It is seen by the next frame's lookup.
- R10: With all 64 table bits 0, no frame matches. With all 64 bits 1, every frame matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is present on `in_data` this cycle |
| in_sof | input | 1 | The present byte is the first of a frame (qualified by `in_valid`) |
| in_data | input | 8 | Frame byte |
| tbl_we | input | 1 | Write strobe for a table register |
| tbl_addr | input | 3 | Table register number 0..7 |
| tbl_wdata | input | 8 | Table register write data |
| match_valid | output | 1 | Lookup result is valid |
| match | output | 1 | Selected table bit |
| hash_idx | output | 6 | Index used for the lookup |

## Verification
The lookup result is due exactly one cycle after the clock edge that takes the sixth address byte. A start-of-frame byte clears that result one cycle after its edge. A table write is visible on the edge after its strobe. The bench drives inputs on the falling edge. It drops `in_valid` on the falling edge that follows the sixth byte and samples there, which is the first point where the registered result can be seen. Checks on holding and clearing then sample one falling edge after each further byte or start-of-frame.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int          ADDR_BYTES = 6,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB7,
  parameter int          IDX_LSB    = 23,
  parameter int          IDX_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [7:0]       in_data,
  input  logic             tbl_we,
  input  logic [IDX_W-4:0] tbl_addr,
  input  logic [7:0]       tbl_wdata,
  output logic             match_valid,
  output logic             match,
  output logic [IDX_W-1:0] hash_idx
);

  localparam int TBL_BITS = 1 << IDX_W;
  localparam int CNT_W    = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  logic [TBL_BITS-1:0] tbl;
  logic [31:0]         crc;
  logic [CNT_W-1:0]    cnt;

  logic             start, take, last;
  logic [31:0]      crc_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic [IDX_W-1:0] idx_nx;

  assign start  = in_valid && in_sof;
  assign take   = in_valid && (in_sof || cnt != CNT_DONE);
  assign crc_nx = crc_byte(in_sof ? 32'hFFFF_FFFF : crc, in_data);
  assign cnt_nx = in_sof ? CNT_ONE : cnt + CNT_ONE;
  assign last   = take && (cnt_nx == CNT_DONE);
  assign idx_nx = crc_nx[IDX_LSB +: IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl <= '0;
    end else if (tbl_we) begin
      tbl[tbl_addr*8 +: 8] <= tbl_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= '1;
      cnt <= CNT_DONE;
    end else if (take) begin
      crc <= crc_nx;
      cnt <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_valid <= 1'b0;
      match       <= 1'b0;
      hash_idx    <= '0;
    end else if (last) begin
      match_valid <= 1'b1;
      match       <= tbl[idx_nx];
      hash_idx    <= idx_nx;
    end else if (start) begin
      match_valid <= 1'b0;
      match       <= 1'b0;
    end
  end

endmodule

// File: rtl/mcast_hash_filter_chk.sv
module mcast_hash_filter_chk #(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic [7:0]       in_data,
  input logic             tbl_we,
  input logic [IDX_W-4:0] tbl_addr,
  input logic [7:0]       tbl_wdata,
  input logic             match_valid,
  input logic             match,
  input logic [IDX_W-1:0] hash_idx
);

  logic [7:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     seen <= 8'd0;
    else if (in_valid && in_sof)    seen <= 8'd1;
    else if (in_valid && seen != 8'hFF) seen <= seen + 8'd1;
  end

  p_flag_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> match_valid);

  p_rise_after_sixth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_valid) |-> (seen == 8'(ADDR_BYTES)) && $past(in_valid));

  p_hold_until_sof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && !(in_valid && in_sof)) |=> match_valid && $stable(match) && $stable(hash_idx));

  p_sof_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> !match_valid);

  p_gap_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !match_valid) |=> !match_valid);

endmodule

bind mcast_hash_filter mcast_hash_filter_chk #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/mcast_hash_filter_tb.sv
module mcast_hash_filter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       tbl_we = 1'b0;
  logic [2:0] tbl_addr = 3'd0;
  logic [7:0] tbl_wdata = 8'd0;
  logic       match_valid, match;
  logic [5:0] hash_idx;

  int checks = 0;
  int errors = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  mcast_hash_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .match_valid(match_valid), .match(match), .hash_idx(hash_idx)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // address byte 0 in bits 47:40
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    logic        b, top;
    c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      b   = a[47 - 8*(n/8) - 7 + (n%8)];
      top = c[31];
      c   = c << 1;
      if (top != b) c = c ^ 32'h04C1_1DB7;
    end
    return c[28:23];
  endfunction

  task automatic load_table(input logic [63:0] t);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 3'(k); tbl_wdata = t[8*k +: 8];
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d, input logic sof);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_data = d;
  endtask

  task automatic gap;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  // sends 6 bytes, optional gaps; returns at the sampling negedge after byte 6
  task automatic send_addr(input logic [47:0] a, input logic [5:0] gaps);
    for (int i = 0; i < 6; i++) begin
      if (gaps[i] && i != 0) gap();
      put_byte(a[47 - 8*i -: 8], i == 0);
    end
    gap();
  endtask

  logic [63:0] tbl_model;
  logic [47:0] addr;
  logic [5:0]  ei;

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 match_valid", 64'(match_valid), 64'd0);
    check("R1 match", 64'(match), 64'd0);
    check("R1 hash_idx", 64'(hash_idx), 64'd0);
    rst_n = 1'b1;

    // R1: cleared table, R3 vector
    addr = 48'h01_00_00_00_01_2C;
    send_addr(addr, 6'd0);
    check("R5 valid after sixth", 64'(match_valid), 64'd1);
    check("R3 vector idx", 64'(hash_idx), 64'h34);
    check("R1 table cleared", 64'(match), 64'd0);

    // R4: only register 6 bit 4 set
    load_table(64'd1 << 52);
    tbl_model = 64'd1 << 52;
    send_addr(addr, 6'd0);
    check("R4 reg6 bit4", 64'(match), 64'd1);

    // R6: payload bytes ignored
    put_byte(8'hFF, 1'b0); put_byte(8'h00, 1'b0); put_byte(8'h5A, 1'b0);
    gap();
    check("R6 valid held", 64'(match_valid), 64'd1);
    check("R6 idx held", 64'(hash_idx), 64'h34);
    check("R6 match held", 64'(match), 64'd1);

    // R7: sof clears, mid-address restart
    put_byte(8'hAA, 1'b1);
    gap();
    check("R7 sof clears valid", 64'(match_valid), 64'd0);
    check("R7 sof clears match", 64'(match), 64'd0);
    put_byte(8'h33, 1'b0);
    put_byte(8'h77, 1'b1);
    put_byte(8'h12, 1'b0);
    gap();
    check("R7 no early valid", 64'(match_valid), 64'd0);
    send_addr(addr, 6'd0);
    check("R7 restart idx", 64'(hash_idx), 64'h34);

    // R9: write during sixth byte not seen, then seen
    for (int i = 0; i < 6; i++) begin
      put_byte(addr[47 - 8*i -: 8], i == 0);
      if (i == 5) begin tbl_we = 1'b1; tbl_addr = 3'd6; tbl_wdata = 8'h00; end
    end
    gap();
    tbl_we = 1'b0;
    check("R9 old table used", 64'(match), 64'd1);
    send_addr(addr, 6'd0);
    check("R9 new table used", 64'(match), 64'd0);
    tbl_model = 64'd0;

    // R2/R4/R8/R10 sweep over table patterns and addresses
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: tbl_model = 64'd0;
        1: tbl_model = ~64'd0;
        2: tbl_model = 64'hA5C3_0F96_1E78_3CD2;
        default: tbl_model = 64'h0123_4567_89AB_CDEF;
      endcase
      load_table(tbl_model);
      for (int f = 0; f < 64; f++) begin
        rng  = next_rng(rng);
        addr = {rng[15:0], next_rng(rng)};
        if (f % 4 == 0) addr[40] = 1'b1;
        rng  = next_rng(rng);
        ei   = ref_idx(addr);
        send_addr(addr, rng[5:0]);
        check("R2 R8 idx", 64'(hash_idx), 64'(ei));
        if (p == 0)      check("R10 all clear", 64'(match), 64'd0);
        else if (p == 1) check("R10 all set", 64'(match), 64'd1);
        else             check("R4 lookup", 64'(match), 64'(tbl_model[ei]));
        check("R5 valid", 64'(match_valid), 64'd1);
      end
    end

    // R4: sweep each index with one-hot table
    for (int k = 0; k < 8; k++) begin
      rng  = next_rng(rng);
      addr = {rng[15:0], next_rng(rng)};
      ei   = ref_idx(addr);
      load_table(64'd1 << ei);
      send_addr(addr, 6'd0);
      check("R4 onehot hit", 64'(match), 64'd1);
      load_table(~(64'd1 << ei));
      send_addr(addr, 6'd0);
      check("R4 onehot miss", 64'(match), 64'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule